// File: doc/BRIEF.md
# IEEE 1588 Time-of-Day Counter

This block keeps a free-running time-of-day value for precision time protocol timestamping. The value has three fields: seconds, nanoseconds and fractional nanoseconds. On every clock it advances by a programmable step, and it presents the full value on one output bus every cycle. The nanosecond field rolls over into the seconds field once it reaches one second.

Software reaches the block through a simple write-only register port. Through this port it can set the time directly, which is a coarse step. It can trim the nominal step, which is a frequency adjustment with no jump in time. It can also put in an alternate step for a set number of cycles, which slews out a phase offset a little at a time.

A master time source can overwrite the whole value through a valid-qualified load port. A software time set that arrives in the same cycle takes priority over that load.

Top module: `tod_counter`

## Requirements
- R1: While reset is asserted the time output is all zeros. Reset also loads the nominal step of 6 ns plus fraction 0x6666 (6.4 ns), so the first cycle after release gives nanoseconds 6 and fraction 0x6666.
- R2: When no load is applied in a cycle, the block adds the active step to the time at each rising edge. A carry out of the 16-bit fraction adds one nanosecond.
- R3: When the nanosecond sum reaches or passes 1,000,000,000, it is reduced by 1,000,000,000 and the seconds field increments in the same cycle. In every other step the seconds field holds.
- R4: Address 3 sets the nominal step: wr_data[31:16] is nanoseconds and wr_data[15:0] is fraction. The step taken in the cycle of the write still uses the old value. The new value takes effect from the next cycle, and the write causes no jump in time.
- R5: Address 4 sets the alternate step, in the same layout as R4. Writing N to address 5 makes the next N steps use the alternate step. The step in the cycle of that write still uses the nominal step, and after the N steps the block returns to the nominal step. A new count write restarts the countdown.
- R6: Address 0 holds seconds bits 47:32 in wr_data[15:0], and address 1 holds seconds bits 31:0. Writing address 2 loads the time in the next cycle: the held seconds, nanoseconds from wr_data, and fraction zero.
- R7: When mst_valid is high, the next cycle shows mst_time exactly, all 96 bits.
- R8: A write to address 2 in the same cycle as mst_valid wins over the master load. That write also replaces the step for that cycle.
- R9: Writes to addresses 0 and 1 alone do not change the time or its progression. Writes to addresses 6 and 7 are ignored.
- R10: The time bus is {seconds[47:0], nanoseconds[31:0], fraction[15:0]}, with the seconds in the most significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| mst_valid | input | 1 | Master time load strobe |
| mst_time | input | 96 | Master time value, same layout as tod_time |
| tod_time | output | 96 | Current time of day |

## Verification
The assertions check these properties on every cycle:
- the seconds field holds or advances by one, as the rollover flag says;
- the nanoseconds field stays below one second across a step;
- a software set gives zero fraction and the written nanoseconds, even when it coincides with a master load;
- a master load shows up unchanged;
- the slew counter counts down one per cycle and stays at zero.

Other behaviours show only in the bench's scenarios, against a reference kept as a single scaled sub-second count:
- the exact step values;
- the one-cycle latency of a step change;
- the exact length of a slew window;
- the reset step;
- the fact that staging and unused writes are harmless.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int TOD_SEC_W  = 48;
  localparam int TOD_NS_W   = 32;
  localparam int TOD_FRAC_W = 16;
  localparam int TOD_PNS_W  = 16;
  localparam int TOD_DATA_W = 32;
  localparam int TOD_ADDR_W = 3;
  localparam int TOD_CNT_W  = 32;
  localparam int unsigned TOD_NS_PER_SEC = 1_000_000_000;
  localparam int unsigned TOD_DEF_PNS    = 6;
  localparam int unsigned TOD_DEF_PFRAC  = 16'h6666;

  // register map; the address 2 commit depends on the address 0/1 staging
  typedef enum logic [2:0] {
    RA_SEC_HI  = 3'd0,
    RA_SEC_LO  = 3'd1,
    RA_NS_SET  = 3'd2,
    RA_PERIOD  = 3'd3,
    RA_ADJ_PER = 3'd4,
    RA_ADJ_CNT = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/tod_regs.sv
`timescale 1ns/1ps
module tod_regs import tod_pkg::*; #(
  parameter int SEC_W  = TOD_SEC_W,
  parameter int NS_W   = TOD_NS_W,
  parameter int FRAC_W = TOD_FRAC_W,
  parameter int PNS_W  = TOD_PNS_W,
  parameter int DATA_W = TOD_DATA_W,
  parameter int ADDR_W = TOD_ADDR_W,
  parameter int CNT_W  = TOD_CNT_W,
  parameter int unsigned DEF_PNS   = TOD_DEF_PNS,
  parameter int unsigned DEF_PFRAC = TOD_DEF_PFRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PNS_W-1:0]  nom_ns,
  output logic [FRAC_W-1:0] nom_frac,
  output logic [PNS_W-1:0]  alt_ns,
  output logic [FRAC_W-1:0] alt_frac,
  output logic              set_ld,
  output logic [SEC_W-1:0]  set_sec,
  output logic [NS_W-1:0]   set_ns,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_val
);
  localparam int SHI_W = SEC_W - DATA_W;

  logic [SHI_W-1:0]  sec_hi_q;
  logic [DATA_W-1:0] sec_lo_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
    return a == ADDR_W'(r);
  endfunction

  logic w_hi, w_lo, w_per, w_alt;
  assign w_hi   = wr_en && hit(wr_addr, RA_SEC_HI);
  assign w_lo   = wr_en && hit(wr_addr, RA_SEC_LO);
  assign w_per  = wr_en && hit(wr_addr, RA_PERIOD);
  assign w_alt  = wr_en && hit(wr_addr, RA_ADJ_PER);
  assign set_ld = wr_en && hit(wr_addr, RA_NS_SET);
  assign cnt_ld = wr_en && hit(wr_addr, RA_ADJ_CNT);

  assign set_sec = {sec_hi_q, sec_lo_q};
  assign set_ns  = wr_data[NS_W-1:0];
  assign cnt_val = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_hi_q <= '0;
      sec_lo_q <= '0;
      nom_ns   <= PNS_W'(DEF_PNS);
      nom_frac <= FRAC_W'(DEF_PFRAC);
      alt_ns   <= PNS_W'(DEF_PNS);
      alt_frac <= FRAC_W'(DEF_PFRAC);
    end else begin
      if (w_hi)  sec_hi_q <= wr_data[SHI_W-1:0];
      if (w_lo)  sec_lo_q <= wr_data;
      if (w_per) begin
        nom_ns   <= wr_data[FRAC_W +: PNS_W];
        nom_frac <= wr_data[FRAC_W-1:0];
      end
      if (w_alt) begin
        alt_ns   <= wr_data[FRAC_W +: PNS_W];
        alt_frac <= wr_data[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tod_slew.sv
`timescale 1ns/1ps
module tod_slew #(
  parameter int PNS_W  = 16,
  parameter int FRAC_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_ld,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [PNS_W-1:0]  nom_ns,
  input  logic [FRAC_W-1:0] nom_frac,
  input  logic [PNS_W-1:0]  alt_ns,
  input  logic [FRAC_W-1:0] alt_frac,
  output logic [PNS_W-1:0]  step_ns,
  output logic [FRAC_W-1:0] step_frac,
  output logic [CNT_W-1:0]  slew_cnt,
  output logic              slew_active
);
  logic [CNT_W-1:0] cnt_q;

  assign slew_active = (cnt_q != '0);
  assign slew_cnt    = cnt_q;
  assign step_ns     = slew_active ? alt_ns   : nom_ns;
  assign step_frac   = slew_active ? alt_frac : nom_frac;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (cnt_ld)      cnt_q <= cnt_val;
    else if (slew_active) cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/tod_accum.sv
`timescale 1ns/1ps
module tod_accum #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int FRAC_W = 16,
  parameter int PNS_W  = 16,
  parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PNS_W-1:0]              step_ns,
  input  logic [FRAC_W-1:0]             step_frac,
  input  logic                          set_ld,
  input  logic [SEC_W-1:0]              set_sec,
  input  logic [NS_W-1:0]               set_ns,
  input  logic                          mst_ld,
  input  logic [SEC_W+NS_W+FRAC_W-1:0]  mst_time,
  output logic [SEC_W+NS_W+FRAC_W-1:0]  tod_time,
  output logic                          wrap_evt
);
  localparam logic [NS_W:0] NS_LIM = (NS_W+1)'(NS_PER_SEC);
  localparam int RES_W = 1 + NS_W + FRAC_W;

  logic [SEC_W-1:0]  sec_q;
  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;

  // returns {wrap, ns, frac} after adding one step
  function automatic logic [RES_W-1:0] advance(
    input logic [NS_W-1:0]   ns,
    input logic [FRAC_W-1:0] fr,
    input logic [PNS_W-1:0]  sns,
    input logic [FRAC_W-1:0] sfr
  );
    logic [FRAC_W:0] fsum;
    logic [NS_W:0]   nsum;
    logic            w;
    fsum = {1'b0, fr} + {1'b0, sfr};
    nsum = {1'b0, ns} + (NS_W+1)'(sns) + (NS_W+1)'(fsum[FRAC_W]);
    w    = (nsum >= NS_LIM);
    if (w) nsum = nsum - NS_LIM;
    return {w, nsum[NS_W-1:0], fsum[FRAC_W-1:0]};
  endfunction

  logic [RES_W-1:0]  nxt;
  logic [NS_W-1:0]   ns_inc;
  logic [FRAC_W-1:0] frac_inc;

  assign nxt      = advance(ns_q, frac_q, step_ns, step_frac);
  assign wrap_evt = nxt[RES_W-1];
  assign ns_inc   = nxt[FRAC_W +: NS_W];
  assign frac_inc = nxt[FRAC_W-1:0];
  assign tod_time = {sec_q, ns_q, frac_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else if (set_ld) begin
      sec_q  <= set_sec;
      ns_q   <= set_ns;
      frac_q <= '0;
    end else if (mst_ld) begin
      sec_q  <= mst_time[NS_W+FRAC_W +: SEC_W];
      ns_q   <= mst_time[FRAC_W +: NS_W];
      frac_q <= mst_time[FRAC_W-1:0];
    end else begin
      sec_q  <= sec_q + SEC_W'(wrap_evt);
      ns_q   <= ns_inc;
      frac_q <= frac_inc;
    end
  end
endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter import tod_pkg::*; #(
  parameter int SEC_W  = TOD_SEC_W,
  parameter int NS_W   = TOD_NS_W,
  parameter int FRAC_W = TOD_FRAC_W,
  parameter int PNS_W  = TOD_PNS_W,
  parameter int DATA_W = TOD_DATA_W,
  parameter int ADDR_W = TOD_ADDR_W,
  parameter int CNT_W  = TOD_CNT_W,
  parameter int unsigned NS_PER_SEC = TOD_NS_PER_SEC,
  parameter int unsigned DEF_PNS    = TOD_DEF_PNS,
  parameter int unsigned DEF_PFRAC  = TOD_DEF_PFRAC
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         mst_valid,
  input  logic [SEC_W+NS_W+FRAC_W-1:0] mst_time,
  output logic [SEC_W+NS_W+FRAC_W-1:0] tod_time
);
  logic [PNS_W-1:0]  nom_ns, alt_ns, step_ns;
  logic [FRAC_W-1:0] nom_frac, alt_frac, step_frac;
  logic              set_ld, cnt_ld, mst_ld, wrap_evt, slew_active;
  logic [SEC_W-1:0]  set_sec;
  logic [NS_W-1:0]   set_ns;
  logic [CNT_W-1:0]  cnt_val, slew_cnt;

  assign mst_ld = mst_valid && !set_ld;

  tod_regs #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .PNS_W(PNS_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .DEF_PNS(DEF_PNS), .DEF_PFRAC(DEF_PFRAC)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .nom_ns(nom_ns), .nom_frac(nom_frac), .alt_ns(alt_ns), .alt_frac(alt_frac),
    .set_ld(set_ld), .set_sec(set_sec), .set_ns(set_ns),
    .cnt_ld(cnt_ld), .cnt_val(cnt_val)
  );

  tod_slew #(.PNS_W(PNS_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_slew (
    .clk(clk), .rst_n(rst_n), .cnt_ld(cnt_ld), .cnt_val(cnt_val),
    .nom_ns(nom_ns), .nom_frac(nom_frac), .alt_ns(alt_ns), .alt_frac(alt_frac),
    .step_ns(step_ns), .step_frac(step_frac),
    .slew_cnt(slew_cnt), .slew_active(slew_active)
  );

  tod_accum #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .PNS_W(PNS_W), .NS_PER_SEC(NS_PER_SEC)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .step_ns(step_ns), .step_frac(step_frac),
    .set_ld(set_ld), .set_sec(set_sec), .set_ns(set_ns),
    .mst_ld(mst_ld), .mst_time(mst_time),
    .tod_time(tod_time), .wrap_evt(wrap_evt)
  );
endmodule

// File: rtl/tod_counter_chk.sv
`timescale 1ns/1ps
module tod_counter_chk #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int FRAC_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [DATA_W-1:0]            wr_data,
  input logic                         mst_valid,
  input logic [SEC_W+NS_W+FRAC_W-1:0] mst_time,
  input logic [SEC_W+NS_W+FRAC_W-1:0] tod_time,
  input logic                         set_ld,
  input logic                         cnt_ld,
  input logic                         wrap_evt,
  input logic [CNT_W-1:0]             slew_cnt
);
  logic [SEC_W-1:0]  sec;
  logic [NS_W-1:0]   ns;
  logic [FRAC_W-1:0] frac;
  logic              stepping;
  assign sec      = tod_time[NS_W+FRAC_W +: SEC_W];
  assign ns       = tod_time[FRAC_W +: NS_W];
  assign frac     = tod_time[FRAC_W-1:0];
  assign stepping = !set_ld && !mst_valid;

  // R3
  wrap_adds_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepping && wrap_evt |=> sec == $past(sec) + SEC_W'(1));
  // R3
  nowrap_holds_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepping && !wrap_evt |=> sec == $past(sec));
  // R3
  ns_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepping && (ns < NS_W'(NS_PER_SEC)) |=> ns < NS_W'(NS_PER_SEC));
  // R6
  set_loads_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ld |=> (ns == $past(wr_data[NS_W-1:0])) && (frac == '0));
  // R8
  set_beats_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ld && mst_valid |=> ns == $past(wr_data[NS_W-1:0]));
  // R7
  master_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid && !set_ld |=> tod_time == $past(mst_time));
  // R5
  slew_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slew_cnt != '0) && !cnt_ld |=> slew_cnt == $past(slew_cnt) - CNT_W'(1));
  // R5
  slew_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slew_cnt == '0) && !cnt_ld |=> slew_cnt == '0);
endmodule

bind tod_counter tod_counter_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W),
  .CNT_W(CNT_W), .NS_PER_SEC(NS_PER_SEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .mst_valid(mst_valid),
  .mst_time(mst_time), .tod_time(tod_time), .set_ld(set_ld), .cnt_ld(cnt_ld),
  .wrap_evt(wrap_evt), .slew_cnt(slew_cnt)
);

// File: tb/sim_tod_counter.sv
`timescale 1ns/1ps
module sim_tod_counter;
  localparam real CLK_PERIOD = 6.4;
  localparam logic [63:0] SUB_LIM = 64'd1_000_000_000 << 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        mst_valid = 1'b0;
  logic [95:0] mst_time = '0;
  logic [95:0] tod_time;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_counter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mst_valid(mst_valid), .mst_time(mst_time), .tod_time(tod_time)
  );

  // reference: seconds plus sub-second count scaled by 2^16
  logic [47:0] m_sec;
  logic [63:0] m_sub, m_inc;
  logic [15:0] m_pn, m_pf, m_an, m_af, m_shi;
  logic [31:0] m_slo, m_cnt;

  function automatic logic [63:0] scaled(input logic [15:0] n, input logic [15:0] f);
    return (64'(n) << 16) + 64'(f);
  endfunction

  function automatic logic [95:0] model_time(input logic [47:0] s, input logic [63:0] sub);
    return {s, sub[47:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = '0; m_sub = '0; m_pn = 16'd6; m_pf = 16'h6666;
      m_an = 16'd6; m_af = 16'h6666; m_shi = '0; m_slo = '0; m_cnt = '0;
    end else begin
      m_inc = (m_cnt != 0) ? scaled(m_an, m_af) : scaled(m_pn, m_pf);
      if (wr_en && wr_addr == 3'd2) begin
        m_sec = {m_shi, m_slo};
        m_sub = 64'(wr_data) << 16;
      end else if (mst_valid) begin
        m_sec = mst_time[95:48];
        m_sub = 64'(mst_time[47:0]);
      end else begin
        m_sub = m_sub + m_inc;
        if (m_sub >= SUB_LIM) begin
          m_sub = m_sub - SUB_LIM;
          m_sec = m_sec + 48'd1;
        end
      end
      if (wr_en && wr_addr == 3'd0) m_shi = wr_data[15:0];
      if (wr_en && wr_addr == 3'd1) m_slo = wr_data;
      if (wr_en && wr_addr == 3'd3) begin m_pn = wr_data[31:16]; m_pf = wr_data[15:0]; end
      if (wr_en && wr_addr == 3'd4) begin m_an = wr_data[31:16]; m_af = wr_data[15:0]; end
      if (wr_en && wr_addr == 3'd5) m_cnt = wr_data;
      else if (m_cnt != 0) m_cnt = m_cnt - 32'd1;
    end
  end

  task automatic chk(input string req, input logic [95:0] got, input logic [95:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic tick(input string req);
    @(negedge clk);
    chk(req, tod_time, model_time(m_sec, m_sub));
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(req);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ns_of(input logic [95:0] t);
    return t[47:16];
  endfunction

  logic [31:0] prev_ns;
  logic [95:0] mt;

  initial begin
    void'($urandom(32'd1588));
    repeat (3) @(negedge clk);
    chk("R1", tod_time, 96'd0);
    rst_n = 1'b1;
    // R1 / R2: default 6.4 ns step
    @(negedge clk); chk("R1", tod_time, {48'd0, 32'd6, 16'h6666});
    @(negedge clk); chk("R2", tod_time, {48'd0, 32'd12, 16'hCCCC});
    @(negedge clk); chk("R2", tod_time, {48'd0, 32'd19, 16'h3332});
    // R9: staging only; R6: commit
    wr(3'd0, 32'd0, "R9");
    wr(3'd1, 32'd5, "R9");
    wr(3'd2, 32'd999_999_990, "R6");
    chk("R6", tod_time, {48'd5, 32'd999_999_990, 16'h0000});
    @(negedge clk); chk("R2", tod_time, {48'd5, 32'd999_999_996, 16'h6666});
    @(negedge clk); chk("R3", tod_time, {48'd6, 32'd2, 16'hCCCC});
    // R4: new nominal step 10.0 ns
    wr(3'd3, {16'd10, 16'd0}, "R4");
    prev_ns = ns_of(tod_time);
    tick("R4");
    chk("R4", 96'(ns_of(tod_time)), 96'(prev_ns + 32'd10));
    // R5: alternate 1 ns for 3 steps
    wr(3'd4, {16'd1, 16'd0}, "R5");
    prev_ns = ns_of(tod_time);
    wr(3'd5, 32'd3, "R5");
    chk("R5", 96'(ns_of(tod_time)), 96'(prev_ns + 32'd10));
    for (int i = 0; i < 4; i++) begin
      prev_ns = ns_of(tod_time);
      tick("R5");
      chk("R5", 96'(ns_of(tod_time)), 96'(prev_ns + ((i < 3) ? 32'd1 : 32'd10)));
    end
    // R7 / R10: master load
    mst_valid = 1'b1;
    mst_time = {48'h1234_5678_9ABC, 32'd500, 16'hBEEF};
    tick("R7");
    mst_valid = 1'b0;
    chk("R10", tod_time, {48'h1234_5678_9ABC, 32'd500, 16'hBEEF});
    // R8: software set beats master
    wr(3'd1, 32'd77, "R9");
    mst_valid = 1'b1;
    mst_time = {48'd9, 32'd9, 16'd9};
    wr(3'd2, 32'd123, "R8");
    mst_valid = 1'b0;
    chk("R8", tod_time, {48'd77, 32'd123, 16'd0});
    // R9: unused addresses
    prev_ns = ns_of(tod_time);
    wr(3'd6, 32'hFFFF_FFFF, "R9");
    chk("R9", 96'(ns_of(tod_time)), 96'(prev_ns + 32'd10));
    prev_ns = ns_of(tod_time);
    wr(3'd7, 32'h0001_0000, "R9");
    chk("R9", 96'(ns_of(tod_time)), 96'(prev_ns + 32'd10));
    wr(3'd3, {16'd6, 16'h6666}, "R4");
    // random mix
    for (int c = 0; c < 4000; c++) begin
      int op;
      string tag;
      op = $urandom_range(0, 99);
      tag = "R2";
      if (op < 4) begin
        wr_en = 1'b1; wr_addr = 3'd3; tag = "R4";
        wr_data = {16'($urandom_range(4, 8)), 16'($urandom)};
      end else if (op < 8) begin
        wr_en = 1'b1; wr_addr = 3'd4; tag = "R5";
        wr_data = {16'($urandom_range(0, 12)), 16'($urandom)};
      end else if (op < 11) begin
        wr_en = 1'b1; wr_addr = 3'd5; tag = "R5";
        wr_data = 32'($urandom_range(0, 30));
      end else if (op < 15) begin
        wr_en = 1'b1; wr_addr = 3'($urandom_range(0, 1)); tag = "R9";
        wr_data = $urandom;
      end else if (op < 19) begin
        wr_en = 1'b1; wr_addr = 3'd2; tag = "R6";
        wr_data = 32'd1_000_000_000 - 32'($urandom_range(1, 40));
      end else if (op < 22) begin
        mt = {16'($urandom), 32'($urandom), 32'($urandom_range(0, 999_999_999)), 16'($urandom)};
        mst_valid = 1'b1; mst_time = mt; tag = "R7";
        if (op == 21) begin
          wr_en = 1'b1; wr_addr = 3'd2; tag = "R8";
          wr_data = 32'($urandom_range(0, 999_999_999));
        end
      end else if (op < 25) begin
        wr_en = 1'b1; wr_addr = 3'($urandom_range(6, 7)); tag = "R9";
        wr_data = $urandom;
      end else begin
        wr_en = 1'b0;
      end
      tick(tag);
      wr_en = 1'b0; mst_valid = 1'b0;
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule